// File: doc/BRIEF.md
# Instruction Word Decoder with Legality Check

This block takes one 16-bit instruction word and breaks it into its fields: a 5-bit opcode, a 3-bit destination register, two operand register indices and an 8-bit immediate. It sorts every opcode into one of three formats:

- register-register (A),
- register-immediate (I),
- register-free (J).

It flags any encoding the machine does not accept. It also drives a set of one-hot control strobes for the execution stage. These cover ALU function, register write, data-memory read and write, port input and output, stack push and pop, the five jump flavours, return, halt and return-from-interrupt.

Legality depends on the format:

- An A-format word whose operand nibble has its top bit set is illegal.
- A J-format word with a nonzero register field is illegal.
- Opcodes 27 to 31 are always illegal.

When a word is illegal, every control strobe is held low. The execution stage can then raise its fault without undoing any effect. The fields are still presented so that the fault handler can inspect them.

Parameter `OUT_STAGE` (default 1) adds one register stage on all outputs, giving one cycle of latency. With `OUT_STAGE` = 0 the block is purely combinational.

Top module: `insn_decoder`

## Requirements
- R1: With the default output stage, one clock edge after `instr_i` is presented, the outputs hold its fields: `opc_o` = bits 15:11, `rd_o` = bits 10:8, `ra_o` = bits 6:4, `rb_o` = bits 2:0, `imm_o` = bits 7:0. These fields are shown whether or not the word is legal.
- R2: `fmt_o` is one-hot: bit 0 means A format, bit 1 I format, bit 2 J format.
  - A format: opcodes 4, 5, 7 to 13 and 22 to 25.
  - I format: opcodes 1, 2, 3, 6, 14 to 17, 19 and 20.
  - J format: every other opcode, including 27 to 31.
- R3: An A-format word with bit 7 or bit 3 set raises `illegal_o`.
- R4: A J-format word with bits 10:8 nonzero raises `illegal_o`.
- R5: Opcodes 27 to 31 raise `illegal_o` regardless of the other bits. No other condition raises it.
- R6: While `illegal_o` is high, every control strobe (`alu_sel_o`, `reg_we_o`, memory, port, stack, `jmp_o`, `ret_o`, `halt_o`, `iret_o`) is low.
- R7: `alu_sel_o` is one-hot for legal ALU opcodes and zero otherwise. The bit positions are:
  - bits 0 to 2: opcodes 4, 5 and 6 (add, subtract, add-immediate);
  - bits 3 to 9: opcodes 7 to 13 (and, or, xor, shift left, shift right, arithmetic shift right, rotate);
  - bits 10 and 11: opcodes 22 and 23 (less-than and equal).
- R8: `reg_we_o` is high only for a legal word with `rd_o` nonzero and opcode 2, 3, 4 to 13, 15, 22, 23 or 25. Writes to register 0 are never requested.
- R9: For a legal word, each of these strobes is high exactly when the opcode matches:
  - `io_out_o`: opcode 1; `io_in_o`: opcode 2;
  - `push_o`: opcode 14; `pop_o`: opcode 15;
  - `mem_wr_o`: opcode 24; `mem_rd_o`: opcode 25.
- R10: `jmp_o` is one-hot for legal jumps and zero otherwise. Bit 0 is opcode 16 (short, linked), bit 1 is 17 (short), bit 2 is 18 (long, linked), bit 3 is 19 (conditional short) and bit 4 is 20 (conditional long).
- R11: For a legal word, `halt_o` is high exactly for opcode 0, `ret_o` exactly for opcode 21 and `iret_o` exactly for opcode 26.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word to decode |
| opc_o | output | 5 | Opcode field |
| rd_o | output | 3 | Destination / condition register |
| ra_o | output | 3 | First operand register index |
| rb_o | output | 3 | Second operand register index |
| imm_o | output | 8 | Immediate byte |
| fmt_o | output | 3 | One-hot format: A, I, J |
| illegal_o | output | 1 | Encoding is not accepted |
| alu_sel_o | output | 12 | One-hot ALU function select |
| reg_we_o | output | 1 | Destination register write request |
| mem_rd_o | output | 1 | Data memory load |
| mem_wr_o | output | 1 | Data memory store |
| io_in_o | output | 1 | Port input |
| io_out_o | output | 1 | Port output |
| push_o | output | 1 | Data stack push |
| pop_o | output | 1 | Data stack pop |
| jmp_o | output | 5 | One-hot jump kind |
| ret_o | output | 1 | Return from call |
| halt_o | output | 1 | Halt |
| iret_o | output | 1 | Return from interrupt |

## Verification
The hardest cases to reach are the illegal words that look almost legal. Examples are a register-writing A-format word whose only defect is bit 3 of the second byte, or a halt word with a nonzero register field. Each must suppress every strobe while still showing its fields.

Hand-picked vectors would only touch a few of these. The bench therefore sweeps all 65536 instruction words, one per cycle, through the registered stage. It compares every output against a model built from the opcode tables and legality rules, so every opcode meets every nibble pattern and every register field.

// File: rtl/insn_pkg.sv
package insn_pkg;
  localparam int INSN_W = 16;
  localparam int OPC_W  = 5;
  localparam int REG_W  = 3;
  localparam int NIB_W  = 4;
  localparam int IMM_W  = 8;
  localparam int ALU_N  = 12;
  localparam int JMP_N  = 5;
  localparam int FMT_N  = 3;

  localparam int FMT_A = 0;
  localparam int FMT_I = 1;
  localparam int FMT_J = 2;

  localparam logic [OPC_W-1:0] OPC_FIRST_RSV = 5'd27;

  typedef enum logic [OPC_W-1:0] {
    K_STOP = 5'd0,  K_PORTW = 5'd1,  K_PORTR = 5'd2,  K_LDIMM = 5'd3,
    K_ADD  = 5'd4,  K_SUB   = 5'd5,  K_ADDI  = 5'd6,  K_AND   = 5'd7,
    K_OR   = 5'd8,  K_XOR   = 5'd9,  K_SLL   = 5'd10, K_SRL   = 5'd11,
    K_SRA  = 5'd12, K_ROT   = 5'd13, K_PUSH  = 5'd14, K_POP   = 5'd15,
    K_BSL  = 5'd16, K_BS    = 5'd17, K_BLL   = 5'd18, K_BCS   = 5'd19,
    K_BCL  = 5'd20, K_BACK  = 5'd21, K_SLT   = 5'd22, K_SEQ   = 5'd23,
    K_STORE= 5'd24, K_LOAD  = 5'd25, K_IBACK = 5'd26
  } opc_e;

  typedef struct packed {
    logic [ALU_N-1:0] alu_sel;
    logic             reg_we;
    logic             mem_rd;
    logic             mem_wr;
    logic             io_in;
    logic             io_out;
    logic             push;
    logic             pop;
    logic [JMP_N-1:0] jmp;
    logic             ret;
    logic             halt;
    logic             iret;
  } ctl_t;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd;
    logic [NIB_W-1:0] ra;
    logic [NIB_W-1:0] rb;
    logic [IMM_W-1:0] imm;
  } fld_t;
endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output fld_t              fld_o,
  output logic [FMT_N-1:0]  fmt_o
);
  always_comb begin
    fld_o.opc = word_i[15:11];
    fld_o.rd  = word_i[10:8];
    fld_o.ra  = word_i[7:4];
    fld_o.rb  = word_i[3:0];
    fld_o.imm = word_i[7:0];
  end

  always_comb begin
    fmt_o = '0;
    case (word_i[15:11])
      K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLL, K_SRL, K_SRA, K_ROT,
      K_SLT, K_SEQ, K_STORE, K_LOAD:
        fmt_o[FMT_A] = 1'b1;
      K_PORTW, K_PORTR, K_LDIMM, K_ADDI, K_PUSH, K_POP, K_BSL, K_BS,
      K_BCS, K_BCL:
        fmt_o[FMT_I] = 1'b1;
      default:
        fmt_o[FMT_J] = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_ctl.sv
module insn_ctl
  import insn_pkg::*;
(
  input  fld_t             fld_i,
  input  logic [FMT_N-1:0] fmt_i,
  output logic             illegal_o,
  output ctl_t             ctl_o
);
  ctl_t raw;
  logic rsv, bad_nib, bad_rd, rd_nz;

  assign rd_nz = |fld_i.rd;

  always_comb begin
    raw = '0;
    case (fld_i.opc)
      K_STOP:  raw.halt    = 1'b1;
      K_PORTW: raw.io_out  = 1'b1;
      K_PORTR: begin raw.io_in = 1'b1; raw.reg_we = rd_nz; end
      K_LDIMM: raw.reg_we  = rd_nz;
      K_ADD:   begin raw.alu_sel[0]  = 1'b1; raw.reg_we = rd_nz; end
      K_SUB:   begin raw.alu_sel[1]  = 1'b1; raw.reg_we = rd_nz; end
      K_ADDI:  begin raw.alu_sel[2]  = 1'b1; raw.reg_we = rd_nz; end
      K_AND:   begin raw.alu_sel[3]  = 1'b1; raw.reg_we = rd_nz; end
      K_OR:    begin raw.alu_sel[4]  = 1'b1; raw.reg_we = rd_nz; end
      K_XOR:   begin raw.alu_sel[5]  = 1'b1; raw.reg_we = rd_nz; end
      K_SLL:   begin raw.alu_sel[6]  = 1'b1; raw.reg_we = rd_nz; end
      K_SRL:   begin raw.alu_sel[7]  = 1'b1; raw.reg_we = rd_nz; end
      K_SRA:   begin raw.alu_sel[8]  = 1'b1; raw.reg_we = rd_nz; end
      K_ROT:   begin raw.alu_sel[9]  = 1'b1; raw.reg_we = rd_nz; end
      K_PUSH:  raw.push    = 1'b1;
      K_POP:   begin raw.pop = 1'b1; raw.reg_we = rd_nz; end
      K_BSL:   raw.jmp[0]  = 1'b1;
      K_BS:    raw.jmp[1]  = 1'b1;
      K_BLL:   raw.jmp[2]  = 1'b1;
      K_BCS:   raw.jmp[3]  = 1'b1;
      K_BCL:   raw.jmp[4]  = 1'b1;
      K_BACK:  raw.ret     = 1'b1;
      K_SLT:   begin raw.alu_sel[10] = 1'b1; raw.reg_we = rd_nz; end
      K_SEQ:   begin raw.alu_sel[11] = 1'b1; raw.reg_we = rd_nz; end
      K_STORE: raw.mem_wr  = 1'b1;
      K_LOAD:  begin raw.mem_rd = 1'b1; raw.reg_we = rd_nz; end
      K_IBACK: raw.iret    = 1'b1;
      default: raw = '0;
    endcase
  end

  always_comb begin
    rsv       = (fld_i.opc >= OPC_FIRST_RSV);
    bad_nib   = fmt_i[FMT_A] & (fld_i.ra[NIB_W-1] | fld_i.rb[NIB_W-1]);
    bad_rd    = fmt_i[FMT_J] & rd_nz;
    illegal_o = rsv | bad_nib | bad_rd;
    ctl_o     = illegal_o ? '0 : raw;
  end
endmodule

// File: rtl/insn_outstage.sv
module insn_outstage #(
  parameter int  W         = 8,
  parameter bit  OUT_STAGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (OUT_STAGE) begin : g_reg
      logic [W-1:0] q_nxt, q_r;
      always_comb q_nxt = d_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
      assign q_o = q_r;
    end else begin : g_comb
      assign q_o = rst_n ? d_i : '0;
    end
  endgenerate
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_pkg::*;
#(
  parameter bit OUT_STAGE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr_i,
  output logic [4:0]  opc_o,
  output logic [2:0]  rd_o,
  output logic [2:0]  ra_o,
  output logic [2:0]  rb_o,
  output logic [7:0]  imm_o,
  output logic [2:0]  fmt_o,
  output logic        illegal_o,
  output logic [11:0] alu_sel_o,
  output logic        reg_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        io_in_o,
  output logic        io_out_o,
  output logic        push_o,
  output logic        pop_o,
  output logic [4:0]  jmp_o,
  output logic        ret_o,
  output logic        halt_o,
  output logic        iret_o
);
  localparam int BUS_W = $bits(fld_t) + FMT_N + 1 + $bits(ctl_t);

  fld_t             fld, fld_q;
  logic [FMT_N-1:0] fmt, fmt_q;
  logic             ill, ill_q;
  ctl_t             ctl, ctl_q;
  logic [BUS_W-1:0] bus_d, bus_q;

  insn_fields u_fields (.word_i(instr_i), .fld_o(fld), .fmt_o(fmt));
  insn_ctl    u_ctl    (.fld_i(fld), .fmt_i(fmt), .illegal_o(ill), .ctl_o(ctl));

  assign bus_d = {fld, fmt, ill, ctl};

  insn_outstage #(.W(BUS_W), .OUT_STAGE(OUT_STAGE)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(bus_d), .q_o(bus_q)
  );

  assign {fld_q, fmt_q, ill_q, ctl_q} = bus_q;

  assign opc_o     = fld_q.opc;
  assign rd_o      = fld_q.rd;
  assign ra_o      = fld_q.ra[REG_W-1:0];
  assign rb_o      = fld_q.rb[REG_W-1:0];
  assign imm_o     = fld_q.imm;
  assign fmt_o     = fmt_q;
  assign illegal_o = ill_q;
  assign alu_sel_o = ctl_q.alu_sel;
  assign reg_we_o  = ctl_q.reg_we;
  assign mem_rd_o  = ctl_q.mem_rd;
  assign mem_wr_o  = ctl_q.mem_wr;
  assign io_in_o   = ctl_q.io_in;
  assign io_out_o  = ctl_q.io_out;
  assign push_o    = ctl_q.push;
  assign pop_o     = ctl_q.pop;
  assign jmp_o     = ctl_q.jmp;
  assign ret_o     = ctl_q.ret;
  assign halt_o    = ctl_q.halt;
  assign iret_o    = ctl_q.iret;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter bit OUT_STAGE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr_i,
  input logic [4:0]  opc_o,
  input logic [2:0]  rd_o,
  input logic [7:0]  imm_o,
  input logic [2:0]  fmt_o,
  input logic        illegal_o,
  input logic [11:0] alu_sel_o,
  input logic        reg_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        io_in_o,
  input logic        io_out_o,
  input logic        push_o,
  input logic        pop_o,
  input logic [4:0]  jmp_o,
  input logic        ret_o,
  input logic        halt_o,
  input logic        iret_o
);
  logic any_ctl;
  assign any_ctl = (|alu_sel_o) | reg_we_o | mem_rd_o | mem_wr_o | io_in_o |
                   io_out_o | push_o | pop_o | (|jmp_o) | ret_o | halt_o | iret_o;

  AST_QUIET_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !any_ctl); // R6
  AST_FMT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fmt_o)); // R2
  AST_ALU_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alu_sel_o)); // R7
  AST_JMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(jmp_o)); // R10
  AST_NO_WR_R0: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (rd_o != 3'd0)); // R8
  AST_JFMT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o[2] && rd_o != 3'd0) |-> illegal_o); // R4
  AST_RSV_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_o >= 5'd27) |-> illegal_o); // R5

  generate
    if (OUT_STAGE) begin : g_lat
      logic live;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
      end
      AST_FIELD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (opc_o == $past(instr_i[15:11]) && imm_o == $past(instr_i[7:0]))); // R1
    end
  endgenerate
endmodule

bind insn_decoder insn_decoder_chk #(.OUT_STAGE(OUT_STAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .opc_o(opc_o), .rd_o(rd_o),
  .imm_o(imm_o), .fmt_o(fmt_o), .illegal_o(illegal_o), .alu_sel_o(alu_sel_o),
  .reg_we_o(reg_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .io_in_o(io_in_o), .io_out_o(io_out_o), .push_o(push_o), .pop_o(pop_o),
  .jmp_o(jmp_o), .ret_o(ret_o), .halt_o(halt_o), .iret_o(iret_o)
);

// File: tb/tb_insn_decoder.sv
`timescale 1ns/1ps
module tb_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr_i;
  logic [4:0]  opc_o;
  logic [2:0]  rd_o, ra_o, rb_o, fmt_o;
  logic [7:0]  imm_o;
  logic        illegal_o, reg_we_o, mem_rd_o, mem_wr_o, io_in_o, io_out_o;
  logic        push_o, pop_o, ret_o, halt_o, iret_o;
  logic [11:0] alu_sel_o;
  logic [4:0]  jmp_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  insn_decoder dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .opc_o(opc_o), .rd_o(rd_o),
    .ra_o(ra_o), .rb_o(rb_o), .imm_o(imm_o), .fmt_o(fmt_o), .illegal_o(illegal_o),
    .alu_sel_o(alu_sel_o), .reg_we_o(reg_we_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .io_in_o(io_in_o), .io_out_o(io_out_o), .push_o(push_o),
    .pop_o(pop_o), .jmp_o(jmp_o), .ret_o(ret_o), .halt_o(halt_o), .iret_o(iret_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input logic [15:0] w);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%04h actual=%0h expected=%0h", tag, w, act, exp);
    end
  endtask

  function automatic logic is_a(input int op);
    return (op == 4 || op == 5 || (op >= 7 && op <= 13) || (op >= 22 && op <= 25));
  endfunction
  function automatic logic is_i(input int op);
    return (op == 1 || op == 2 || op == 3 || op == 6 || (op >= 14 && op <= 17) ||
            op == 19 || op == 20);
  endfunction

  task automatic check_word(input logic [15:0] w);
    int op = int'(w[15:11]);
    logic [2:0] rd = w[10:8];
    logic a = is_a(op), i = is_i(op), j = !is_a(op) && !is_i(op);
    logic rsv = (op >= 27);
    logic badn = a && (w[7] || w[3]);
    logic badr = j && (rd != 0);
    logic bad = rsv || badn || badr;
    logic ok = !bad;
    logic [11:0] alu = '0;
    logic [4:0]  jm = '0;
    logic we;
    logic [31:0] any;
    if (op >= 4 && op <= 13) alu[op-4] = 1'b1;
    if (op == 22) alu[10] = 1'b1;
    if (op == 23) alu[11] = 1'b1;
    if (!ok) alu = '0;
    if (op >= 16 && op <= 20 && ok) jm[op-16] = 1'b1;
    we = ok && (rd != 0) && (op == 2 || op == 3 || (op >= 4 && op <= 13) || op == 15 ||
                             op == 22 || op == 23 || op == 25);
    chk("R1 opc", opc_o, w[15:11], w);
    chk("R1 rd",  rd_o,  w[10:8], w);
    chk("R1 ra",  ra_o,  w[6:4], w);
    chk("R1 rb",  rb_o,  w[2:0], w);
    chk("R1 imm", imm_o, w[7:0], w);
    chk("R2 fmt", fmt_o, {j, i, a}, w);
    if (rsv)       chk("R5 illegal", illegal_o, 1, w);
    else if (badr) chk("R4 illegal", illegal_o, 1, w);
    else           chk("R3 illegal", illegal_o, badn, w);
    any = (|alu_sel_o) | reg_we_o | mem_rd_o | mem_wr_o | io_in_o | io_out_o |
          push_o | pop_o | (|jmp_o) | ret_o | halt_o | iret_o;
    if (bad) chk("R6 quiet", any, 0, w);
    chk("R7 alu", alu_sel_o, alu, w);
    chk("R8 we", reg_we_o, we, w);
    chk("R9 strobes", {io_out_o, io_in_o, push_o, pop_o, mem_wr_o, mem_rd_o},
        {ok && op == 1, ok && op == 2, ok && op == 14, ok && op == 15,
         ok && op == 24, ok && op == 25}, w);
    chk("R10 jmp", jmp_o, jm, w);
    chk("R11 flow", {halt_o, ret_o, iret_o},
        {ok && op == 0, ok && op == 21, ok && op == 26}, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    instr_i = 16'h0000;
    repeat (3) @(negedge clk);
    instr_i = 16'h2345;
    @(negedge clk);
    // R12: outputs stay zero while reset is held
    chk("R12 reset", {opc_o, rd_o, ra_o, rb_o, imm_o, fmt_o, illegal_o}, 0, instr_i);
    chk("R12 reset ctl", {alu_sel_o, reg_we_o, mem_rd_o, mem_wr_o, io_in_o, io_out_o,
                          push_o, pop_o, jmp_o, ret_o, halt_o, iret_o}, 0, instr_i);
    rst_n = 1'b1;
    for (int w = 0; w < 65536; w++) begin
      instr_i = 16'(w);
      @(negedge clk);
      check_word(16'(w));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule